// File: doc/BRIEF.md
# In-Band Interrupt Arbiter and Handler

This block sits in the controller of a two-wire sensor bus. It lets target devices raise interrupts over the shared data and clock lines, so no separate interrupt wire is needed. The data line is modelled as an open-drain wired-AND net. The block only ever pulls it low (`sda_oe_o`) and reads the resolved level back on `sda_i`. The clock line is driven by the controller alone.

While the bus is idle, the block waits for a target to pull the data line low. It then takes the clock low to complete the START and clocks out the address phase. The requesters drive their 7-bit dynamic addresses onto the wired-AND line, most significant bit first. A target that releases a 1 while the line reads 0 drops out, so the lowest address survives. The block looks up the winner in a 128-entry policy table and then acts on the stored policy:

- **Accept:** it ACKs, then reads a configurable number of payload bytes.
- **Passive NACK:** it declines and leaves the target enabled.
- **Disable:** it declines and clears the target's enable bit, so that later requests from that target are NACKed automatically.

Every transaction ends with a STOP.

Top module: `ibi_ctrl`

## Requirements
- R1: After reset and whenever no transaction runs, `scl_o` is 1, `sda_oe_o` is 0 and `busy_o` is 0. A low `sda_i` seen at a clock edge while idle starts a transaction: one cycle later `busy_o` is 1 and `scl_o` is 0.
- R2: The address phase is 8 clock pulses: 7 address bits MSB first, then a read bit. `irq_addr_o` reports the captured address. With several simultaneous requesters that drop out on a lost bit, it equals the lowest of their addresses.
- R3: At the end of the 9th clock pulse, `done_o` pulses for one cycle and `outcome_o` gives the outcome code:
  - 0: accepted
  - 1: passive NACK
  - 2: NACK and disable
  - 3: automatic NACK of a disabled target
- R4: During the 9th clock pulse of the address phase, the block holds `sda_oe_o` high (ACK) only for an enabled target whose policy is accept. Otherwise it leaves the line released (NACK).
- R5: A passive NACK leaves the target enabled. A later request from the same address again yields outcome 1.
- R6: A disable outcome clears the target's enable bit. Every later request from that address yields outcome 3 with a NACK, until the host rewrites the entry.
- R7: A host write (`pol_we_i`, `pol_addr_i`, `pol_mode_i`) stores the policy for that address and sets its enable bit. Mode values are 0 accept, 1 passive NACK, and 2 or 3 disable. After reset every entry is enabled with policy accept.
- R8: On accept, the block reads `payload_len_i` bytes, MSB first. Each byte appears on `rx_data_o` with a one-cycle `rx_valid_o`. The block ACKs every byte except the last, which it NACKs. With a length of 0, the STOP follows the address ACK directly.
- R9: Each transaction ends with a STOP: the data line is pulled low while the clock is low, the clock rises, and then the data line is released while the clock is high. When `busy_o` falls, `scl_o` is 1 and `sda_oe_o` is 0.
- R10: A host write to the address whose enable bit a disable outcome clears in that same cycle takes precedence. The entry ends up enabled with the written policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Resolved level of the wired-AND data line |
| sda_oe_o | output | 1 | Controller pulls the data line low when 1 |
| scl_o | output | 1 | Bus clock driven by the controller |
| payload_len_i | input | LEN_W | Number of payload bytes to read on accept |
| pol_we_i | input | 1 | Policy table write strobe |
| pol_addr_i | input | ADDR_W | Address of the entry to write |
| pol_mode_i | input | 2 | Policy to store (0 accept, 1 passive, 2/3 disable) |
| busy_o | output | 1 | High from START detection until the end of the STOP |
| done_o | output | 1 | One-cycle strobe when the outcome is decided |
| irq_addr_o | output | ADDR_W | Winning target address |
| outcome_o | output | 2 | Outcome code of the last transaction |
| rx_valid_o | output | 1 | One-cycle strobe for each received byte |
| rx_data_o | output | DATA_W | Received payload byte |

## Verification
Two functions can fall in the same clock edge: a host table write, and the hardware clearing of an enable bit after a disable outcome. The clearing lands on the edge that ends the `done_o` strobe. The bench provokes the collision by watching `done_o` and raising a host write to `irq_addr_o` in that same cycle, storing the passive policy. It then judges which function won by sending another request from that address: precedence for the write shows as outcome 1, a lost write as outcome 3.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
  typedef enum logic [1:0] {
    OUT_ACK     = 2'd0,
    OUT_PASSIVE = 2'd1,
    OUT_DISABLE = 2'd2,
    OUT_AUTO    = 2'd3
  } ibi_outcome_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_STOP
  } ibi_state_e;

  localparam logic [1:0] MODE_ACCEPT  = 2'd0;
  localparam logic [1:0] MODE_PASSIVE = 2'd1;
endpackage

// File: rtl/ibi_bit_timer.sv
module ibi_bit_timer #(
  parameter int HALF_PER = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic high_o,
  output logic last_o
);
  localparam int PER  = 2 * HALF_PER;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;

  logic [PH_W-1:0] ph_q;

  assign last_o = (ph_q == PH_W'(PER - 1));
  assign high_o = (ph_q >= PH_W'(HALF_PER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (last_o) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/ibi_shift_in.sv
module ibi_shift_in #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-2:0] sh_q;

  assign nxt_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= nxt_o[W-2:0];
  end
endmodule

// File: rtl/ibi_policy_table.sv
module ibi_policy_table #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_mode_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [1:0]        rd_mode_o,
  output logic              rd_en_o
);
  localparam int N = 1 << ADDR_W;

  logic [N-1:0][1:0] mode_q;
  logic [N-1:0]      en_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[i] <= ibi_pkg::MODE_ACCEPT;
        en_q[i]   <= 1'b1;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
        // host write takes precedence over a same-cycle disable clear
        mode_q[i] <= wr_mode_i;
        en_q[i]   <= 1'b1;
      end else if (clr_i && clr_addr_i == ADDR_W'(i)) begin
        en_q[i]   <= 1'b0;
      end
    end
  end

  assign rd_mode_o = mode_q[rd_addr_i];
  assign rd_en_o   = en_q[rd_addr_i];
endmodule

// File: rtl/ibi_ctrl.sv
module ibi_ctrl
  import ibi_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 4,
  parameter int HALF_PER = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              scl_o,
  input  logic [LEN_W-1:0]  payload_len_i,
  input  logic              pol_we_i,
  input  logic [ADDR_W-1:0] pol_addr_i,
  input  logic [1:0]        pol_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] irq_addr_o,
  output logic [1:0]        outcome_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int SH_W    = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int ACK_A   = ADDR_W + 1;
  localparam int ACK_D   = DATA_W;
  localparam int BIT_MAX = (ACK_A > ACK_D) ? ACK_A : ACK_D;
  localparam int BIT_W   = $clog2(BIT_MAX + 1);

  ibi_state_e        state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  byte_q;
  logic [ADDR_W-1:0] addr_q;
  ibi_outcome_e      out_q, out_now;
  logic              done_q, rxv_q;
  logic [DATA_W-1:0] rx_q;

  logic              ph_high, ph_last;
  logic              samp;
  logic [SH_W-1:0]   sh_nxt;
  logic [1:0]        tbl_mode;
  logic              tbl_en;
  logic              ack_slot_a, ack_slot_d, more_bytes;

  ibi_bit_timer #(.HALF_PER(HALF_PER)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .high_o (ph_high),
    .last_o (ph_last)
  );

  assign ack_slot_a = (state_q == ST_ADDR) && (bit_q == BIT_W'(ACK_A));
  assign ack_slot_d = (state_q == ST_DATA) && (bit_q == BIT_W'(ACK_D));
  assign samp = ph_last && (((state_q == ST_ADDR) && !ack_slot_a) ||
                            ((state_q == ST_DATA) && !ack_slot_d));

  ibi_shift_in #(.W(SH_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (samp),
    .bit_i  (sda_i),
    .nxt_o  (sh_nxt)
  );

  ibi_policy_table #(.ADDR_W(ADDR_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (pol_we_i),
    .wr_addr_i  (pol_addr_i),
    .wr_mode_i  (pol_mode_i),
    .clr_i      (done_q && (out_q == OUT_DISABLE)),
    .clr_addr_i (addr_q),
    .rd_addr_i  (addr_q),
    .rd_mode_o  (tbl_mode),
    .rd_en_o    (tbl_en)
  );

  always_comb begin
    if (!tbl_en) out_now = OUT_AUTO;
    else begin
      unique case (tbl_mode)
        MODE_ACCEPT:  out_now = OUT_ACK;
        MODE_PASSIVE: out_now = OUT_PASSIVE;
        default:      out_now = OUT_DISABLE;
      endcase
    end
  end

  assign more_bytes = ({1'b0, byte_q} + 1'b1) < {1'b0, payload_len_i};

  always_comb begin
    scl_o    = 1'b1;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_IDLE:  scl_o = 1'b1;
      ST_START: scl_o = 1'b0;
      ST_ADDR: begin
        scl_o    = ph_high;
        sda_oe_o = ack_slot_a && (out_now == OUT_ACK);
      end
      ST_DATA: begin
        scl_o    = ph_high;
        sda_oe_o = ack_slot_d && more_bytes;
      end
      ST_STOP: begin
        // period 0: SDA low across a clock pulse; period 1: SDA released, SCL high
        scl_o    = (bit_q == '0) ? ph_high : 1'b1;
        sda_oe_o = (bit_q == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      addr_q  <= '0;
      out_q   <= OUT_ACK;
      done_q  <= 1'b0;
      rxv_q   <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          bit_q <= '0;
          if (!sda_i) state_q <= ST_START;
        end
        ST_START: if (ph_last) begin
          state_q <= ST_ADDR;
          bit_q   <= '0;
        end
        ST_ADDR: if (ph_last) begin
          if (ack_slot_a) begin
            out_q   <= out_now;
            done_q  <= 1'b1;
            bit_q   <= '0;
            byte_q  <= '0;
            state_q <= (out_now == OUT_ACK && payload_len_i != '0) ? ST_DATA : ST_STOP;
          end else begin
            if (bit_q == BIT_W'(ADDR_W - 1)) addr_q <= sh_nxt[ADDR_W-1:0];
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_DATA: if (ph_last) begin
          if (ack_slot_d) begin
            bit_q <= '0;
            if (more_bytes) byte_q  <= byte_q + 1'b1;
            else            state_q <= ST_STOP;
          end else begin
            if (bit_q == BIT_W'(DATA_W - 1)) begin
              rx_q  <= sh_nxt[DATA_W-1:0];
              rxv_q <= 1'b1;
            end
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_STOP: if (ph_last) begin
          if (bit_q == '0) bit_q   <= 1'b1;
          else             state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign irq_addr_o = addr_q;
  assign outcome_o  = out_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/ibi_ctrl_chk.sv
module ibi_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic scl_o,
  input logic busy_o,
  input logic done_o,
  input logic rx_valid_o
);
  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && !sda_oe_o));

  // R9
  pull_low_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_o);

  // R3
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R8
  rx_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> busy_o);
endmodule

bind ibi_ctrl ibi_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .scl_o      (scl_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/ibi_ctrl_tb.sv
module ibi_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       sda_oe, scl, busy, done, rxv;
  logic [6:0] irq_addr;
  logic [1:0] outc;
  logic [7:0] rxd;
  logic [3:0] plen = '0;
  logic       pwe = 1'b0;
  logic [6:0] paddr = '0;
  logic [1:0] pmode = '0;
  logic [3:0] t_drv = 4'hF;
  wire        sda = ~sda_oe & (&t_drv);

  ibi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .sda_oe_o(sda_oe), .scl_o(scl),
    .payload_len_i(plen), .pol_we_i(pwe), .pol_addr_i(paddr), .pol_mode_i(pmode),
    .busy_o(busy), .done_o(done), .irq_addr_o(irq_addr), .outcome_o(outc),
    .rx_valid_o(rxv), .rx_data_o(rxd)
  );

  logic [6:0] ta [4];
  logic       talive [4];
  int         tn;
  logic [7:0] pay [16];
  logic [1:0] m_mode [128];
  logic       m_en [128];
  int n_cmp = 0, n_bad = 0;
  int rx_n = 0, done_n = 0;
  logic [7:0] rx_buf [16];
  logic [1:0] last_out;
  logic [6:0] last_addr;

  always @(negedge clk) begin
    if (rxv) begin
      if (rx_n < 16) rx_buf[rx_n] = rxd;
      rx_n++;
    end
    if (done) begin
      done_n++;
      last_out  = outc;
      last_addr = irq_addr;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [6:0] a, input logic [1:0] m);
    @(negedge clk);
    pwe = 1'b1; paddr = a; pmode = m;
    @(negedge clk);
    pwe = 1'b0;
    m_mode[a] = m;
    m_en[a]   = 1'b1;
  endtask

  function automatic int exp_out(input logic [6:0] a);
    if (!m_en[a]) return 3;
    if (m_mode[a] == 2'd0) return 0;
    if (m_mode[a] == 2'd1) return 1;
    return 2;
  endfunction

  // one transaction among ta[0..tn-1]; the winner is removed from the set
  task automatic run_ibi(input int len);
    int wi, ex, d0;
    wi = 0;
    for (int i = 1; i < tn; i++) if (ta[i] < ta[wi]) wi = i;
    ex = exp_out(ta[wi]);
    @(negedge clk);
    plen = 4'(len);
    rx_n = 0;
    d0 = done_n;
    for (int i = 0; i < 4; i++) begin
      talive[i] = (i < tn);
      t_drv[i]  = !(i < tn);
    end
    @(negedge clk);
    chk("R1", "busy after request", int'(busy), 1);
    chk("R1", "scl low after request", int'(scl), 0);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge scl); #1; end
      for (int i = 0; i < tn; i++)
        if (talive[i]) t_drv[i] = (k < 7) ? ta[i][6-k] : 1'b1;
      @(posedge scl); #1;
      for (int i = 0; i < tn; i++)
        if (talive[i] && t_drv[i] && !sda) talive[i] = 1'b0;
    end
    @(negedge scl); #1;
    t_drv = 4'hF;
    @(posedge scl); #1;
    chk("R4", "address ack slot level", int'(sda), (ex == 0) ? 0 : 1);
    if (ex == 0) begin
      for (int b = 0; b < len; b++) begin
        for (int k = 0; k < 8; k++) begin
          @(negedge scl); #1;
          t_drv[wi] = pay[b][7-k];
        end
        @(negedge scl); #1;
        t_drv[wi] = 1'b1;
        @(posedge scl); #1;
        chk("R8", "byte ack slot level", int'(sda), (b < len - 1) ? 0 : 1);
      end
    end
    while (busy) @(negedge clk);
    chk("R9", "scl after stop", int'(scl), 1);
    chk("R9", "sda_oe after stop", int'(sda_oe), 0);
    chk("R2", "winning address", int'(last_addr), int'(ta[wi]));
    chk("R3", "outcome code", int'(last_out), ex);
    chk("R3", "done strobes", done_n - d0, 1);
    chk("R8", "byte count", rx_n, (ex == 0) ? len : 0);
    if (ex == 0)
      for (int b = 0; b < len; b++) chk("R8", "payload byte", int'(rx_buf[b]), int'(pay[b]));
    if (ex == 2) m_en[ta[wi]] = 1'b0;
    for (int i = wi; i < tn - 1; i++) ta[i] = ta[i+1];
    tn--;
  endtask

  task automatic single(input logic [6:0] a, input int len);
    tn = 1; ta[0] = a;
    run_ibi(len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) begin m_mode[i] = 2'd0; m_en[i] = 1'b1; end
    for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R1", "reset scl", int'(scl), 1);
    chk("R1", "reset sda_oe", int'(sda_oe), 0);
    chk("R1", "reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 reset policy is accept; R8 payload
    single(7'h2A, 3);
    // R8 zero length accept
    single(7'h11, 0);
    // R2 extremes
    single(7'h7F, 1);
    single(7'h00, 2);
    // R2 three-way contention: lowest wins, losers retry
    tn = 3; ta[0] = 7'h55; ta[1] = 7'h23; ta[2] = 7'h24;
    while (tn > 0) run_ibi(2);
    // R5 passive stays enabled
    host_wr(7'h30, 2'd1);
    single(7'h30, 2);
    single(7'h30, 2);
    // R6 disable then auto-NACK, R7 rewrite re-enables
    host_wr(7'h41, 2'd2);
    single(7'h41, 1);
    single(7'h41, 1);
    host_wr(7'h41, 2'd0);
    single(7'h41, 1);
    // R7 mode 3 acts as disable
    host_wr(7'h12, 2'd3);
    single(7'h12, 0);
    single(7'h12, 0);
    // R10 host write in the clear cycle wins
    host_wr(7'h66, 2'd2);
    tn = 1; ta[0] = 7'h66;
    fork
      run_ibi(0);
      begin
        while (!done) @(negedge clk);
        pwe = 1'b1; paddr = irq_addr; pmode = 2'd1;
        @(negedge clk);
        pwe = 1'b0;
      end
    join
    m_mode[7'h66] = 2'd1; m_en[7'h66] = 1'b1;
    @(negedge clk);
    done_n = 0;
    single(7'h66, 0);
    chk("R10", "outcome after same-cycle write", int'(last_out), 1);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      int n;
      n = 1 + int'($urandom % 3);
      tn = 0;
      while (tn < n) begin
        logic [6:0] a;
        bit dup;
        a = 7'($urandom);
        dup = 1'b0;
        for (int j = 0; j < tn; j++) if (ta[j] == a) dup = 1'b1;
        if (!dup) begin ta[tn] = a; tn++; end
      end
      for (int j = 0; j < n; j++)
        if ($urandom % 3 == 0) host_wr(ta[j], 2'($urandom));
      for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
      begin
        int len;
        len = int'($urandom % 5);
        while (tn > 0) run_ibi(len);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule